// File: doc/BRIEF.md
# Display Latch with Level Select

This block sits behind a column driver's data memory. When the latch strobe is high, the block copies the whole row image of 3-bit channel codes into a display latch. It then turns each latched code into a one-hot select vector that chooses one of eight bias levels for that column. The analog transmission gates that pass a bias voltage, and the level shifting in front of them, are outside this block. Only the select vectors leave it.

A polarity input sets how codes map to levels. The input is applied to the incoming word at load time, so the polarity in force on the loading cycle stays with that row until the next load. An active-low clear empties the latch, so every column selects the lowest level. Clear is held high in normal operation.

A synchronous active-high reset puts the block in the same state as a clear. The latch and the select outputs are both registered. A load seen at clock edge N is visible on the outputs after edge N+1.

Top module: `disp_level_sel`

## Requirements
- R1: When `strobe` is high and `clr_n` is high at a clock edge, every channel code is captured at that edge. The outputs show the new row after the next edge and not earlier.
- R2: When `strobe` is low and `clr_n` is high, the latch holds. Changes on `mem_image` have no effect on `sel_out`.
- R3: When a row is loaded with `inv` low, code c selects level c. Bit c of the channel's select field is set, so 3'b111 gives level 7 and 3'b000 gives level 0.
- R4: When a row is loaded with `inv` high, code c selects level 7-c. So 3'b111 gives level 0 and 3'b000 gives level 7.
- R5: `inv` acts only on cycles that load. Changing it while `strobe` is low does not change `sel_out`.
- R6: `clr_n` low at an edge empties the latch, with priority over `strobe`. Every channel selects level 0 (field value 8'b0000_0001) after the following edge. Level 0 persists until the next load.
- R7: Every channel's select field has exactly one bit set at all times.
- R8: `rst` high at an edge forces every channel to level 0. `strobe` is ignored while `rst` is high.
- R9: Channel i takes its code from `mem_image[3i+2:3i]` and drives its select field on `sel_out[8i+7:8i]`, with bit k meaning level k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Active-low synchronous clear of the latch |
| strobe | input | 1 | Latch strobe; loads the row while high |
| inv | input | 1 | Polarity select applied to the word being loaded |
| mem_image | input | NUM_CH*CODE_W | Row of channel codes, channel 0 in the low bits |
| sel_out | output | NUM_CH*2^CODE_W | One-hot level selects, one field per channel |

## Verification
The bench sweeps every code on every channel under both polarities, using a row where neighbouring channels differ. A swapped channel slice or a reversed polarity therefore shows up as a wrong set bit. It checks the exact cycle a load appears on the outputs, so an unregistered or doubly registered path would be caught. It toggles `inv` and the image while the strobe is low, which exposes a design that applies polarity at decode time rather than at load. It asserts clear together with strobe to catch a design that lets the load win, or that clears to an all-zero output instead of level 0.

// File: rtl/dl_pkg.sv
package dl_pkg;
  // Default geometry of one driver row
  parameter int unsigned DL_DEF_CHANNELS = 192;
  parameter int unsigned DL_DEF_CODE_W   = 3;
endpackage

// File: rtl/dl_latch.sv
module dl_latch #(
  parameter int unsigned NUM_CH = dl_pkg::DL_DEF_CHANNELS,
  parameter int unsigned CODE_W = dl_pkg::DL_DEF_CODE_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr_n,
  input  logic                     strobe,
  input  logic                     inv,
  input  logic [NUM_CH*CODE_W-1:0] mem_image,
  output logic [NUM_CH*CODE_W-1:0] codes
);
  localparam int unsigned W = NUM_CH * CODE_W;

  logic [W-1:0] polarity_mask;
  assign polarity_mask = {W{inv}};

  // Clear wins over strobe; polarity folded into the stored word
  always_ff @(posedge clk) begin
    if (rst || !clr_n) begin
      codes <= '0;
    end else if (strobe) begin
      codes <= mem_image ^ polarity_mask;
    end
  end

  // R2: latch holds when not strobed
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !strobe) |=> (codes == $past(codes)));

  // R6: clear empties the latch even with strobe high
  p_clear_latch_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr_n) |=> (codes == '0));

  // R4: a load with polarity high stores the complement of the image
  p_inv_load_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_n && strobe && inv) |=> (~codes == $past(mem_image)));
endmodule

// File: rtl/dl_decode.sv
module dl_decode #(
  parameter int unsigned CODE_W = dl_pkg::DL_DEF_CODE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [CODE_W-1:0]          code,
  output logic [(1 << CODE_W)-1:0]   sel_q
);
  localparam int unsigned LEVELS = 1 << CODE_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= LEVELS'(1);
    end else begin
      sel_q <= LEVELS'(1) << code;
    end
  end

  // R7: exactly one level selected per channel
  p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot(sel_q));
endmodule

// File: rtl/disp_level_sel.sv
module disp_level_sel #(
  parameter int unsigned NUM_CH = dl_pkg::DL_DEF_CHANNELS,
  parameter int unsigned CODE_W = dl_pkg::DL_DEF_CODE_W
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              clr_n,
  input  logic                              strobe,
  input  logic                              inv,
  input  logic [NUM_CH*CODE_W-1:0]          mem_image,
  output logic [NUM_CH*(1 << CODE_W)-1:0]   sel_out
);
  localparam int unsigned LEVELS = 1 << CODE_W;

  logic [NUM_CH*CODE_W-1:0] latched;

  dl_latch #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .clr_n    (clr_n),
    .strobe   (strobe),
    .inv      (inv),
    .mem_image(mem_image),
    .codes    (latched)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [LEVELS-1:0] sel_ch;
    dl_decode #(.CODE_W(CODE_W)) u_dec (
      .clk  (clk),
      .rst  (rst),
      .code (latched[ch*CODE_W +: CODE_W]),
      .sel_q(sel_ch)
    );
    assign sel_out[ch*LEVELS +: LEVELS] = sel_ch;
  end

  // R6: a clear reaches the outputs as level 0 two edges later
  p_clear_level0_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr_n) |-> ##2 (sel_out[LEVELS-1:0] == LEVELS'(1)));

  // R2/R1: with no load and no clear for two edges, the outputs stay put
  p_out_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !strobe) ##1 (clr_n && !strobe) |=> $stable(sel_out));
endmodule

// File: tb/disp_level_sel_bench.sv
`timescale 1ns/1ps
module disp_level_sel_bench;
  localparam int NC = 8;
  localparam int CW = 3;
  localparam int LV = 8;

  logic clk = 1'b0;
  logic rst, clr_n, strobe, inv;
  logic [NC*CW-1:0] img;
  logic [NC*LV-1:0] sel_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  disp_level_sel #(.NUM_CH(NC), .CODE_W(CW)) u_disp_level_sel (
    .clk(clk), .rst(rst), .clr_n(clr_n), .strobe(strobe), .inv(inv),
    .mem_image(img), .sel_out(sel_out)
  );

  function automatic logic [LV-1:0] exp_sel(input int c, input bit pol);
    int lvl = pol ? (7 - c) : c;
    return LV'(1) << lvl;
  endfunction

  task automatic check_row(input logic [NC*CW-1:0] row, input bit pol, input string req);
    for (int ch = 0; ch < NC; ch++) begin
      logic [LV-1:0] act = sel_out[ch*LV +: LV];
      logic [LV-1:0] exp = exp_sel(int'(row[ch*CW +: CW]), pol);
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s ch%0d: actual %b expected %b", req, ch, act, exp);
      end
      checks++;
      if ($countones(act) != 1) begin
        errors++;
        $display("FAIL R7 ch%0d: actual %b expected one bit set", ch, act);
      end
    end
  endtask

  task automatic check_level0(input string req);
    for (int ch = 0; ch < NC; ch++) begin
      checks++;
      if (sel_out[ch*LV +: LV] !== LV'(1)) begin
        errors++;
        $display("FAIL %s ch%0d: actual %b expected %b", req, ch, sel_out[ch*LV +: LV], LV'(1));
      end
    end
  endtask

  // entered just after a negedge; returns one negedge after output update
  task automatic load_row(input logic [NC*CW-1:0] row, input bit pol);
    img = row; inv = pol; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [NC*CW-1:0] make_row(input int base);
    logic [NC*CW-1:0] r;
    for (int ch = 0; ch < NC; ch++) r[ch*CW +: CW] = CW'((base + ch) % 8);
    return r;
  endfunction

  initial begin
    logic [NC*CW-1:0] row_a, row_b;
    rst = 1'b1; clr_n = 1'b1; strobe = 1'b1; inv = 1'b0; img = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); strobe = 1'b0; rst = 1'b0;
    check_level0("R8 reset");

    // R3 R4 R1 R9: exhaustive code sweep, both polarities
    for (int base = 0; base < 8; base++) begin
      for (int p = 0; p < 2; p++) begin
        load_row(make_row(base), p[0]);
        check_row(make_row(base), p[0], p[0] ? "R4 R1 R9" : "R3 R1 R9");
      end
    end

    // R1 latency: not visible one edge after the load
    row_a = make_row(1); row_b = make_row(5);
    load_row(row_a, 1'b0);
    img = row_b; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    check_row(row_a, 1'b0, "R1 early");
    @(negedge clk);
    check_row(row_b, 1'b0, "R1 late");

    // R2: image changes without strobe are ignored
    img = row_a;
    repeat (4) @(negedge clk);
    check_row(row_b, 1'b0, "R2");

    // R5: inv changes without strobe are ignored
    inv = 1'b1;
    repeat (3) @(negedge clk);
    check_row(row_b, 1'b0, "R5 idle");
    load_row(row_a, 1'b1);
    check_row(row_a, 1'b1, "R5 load");

    // R6: clear with strobe high gives level 0
    img = row_b; inv = 1'b0; strobe = 1'b1; clr_n = 1'b0;
    @(negedge clk); clr_n = 1'b1; strobe = 1'b0; inv = 1'b1;
    @(negedge clk);
    check_level0("R6 clear");
    repeat (3) @(negedge clk);
    check_level0("R6 persist");

    // R8: reset with strobe high discards the load
    load_row(row_a, 1'b0);
    rst = 1'b1; strobe = 1'b1; img = row_b;
    @(negedge clk); rst = 1'b0; strobe = 1'b0;
    check_level0("R8 strobe ignored");
    @(negedge clk);
    check_level0("R8 held");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule